// File: doc/BRIEF.md
# Channel-Skew Phase Calibrator

This block lines up the current and voltage sample streams of one metering phase. It does this by holding one of the two streams back by a whole number of sample periods. Current transducers often add a small phase lead or lag, and that error shows up most at low power factor. The block cancels it by moving one channel against the other in steps of one sample period. At a 1.024 MHz sample rate one step is about 0.976 µs. The design is placed once for each phase.

A single 10-bit calibration value sets the skew, and it is accessed as a 16-bit word.

- **Bit 9 clear:** the value, 0 to 383, asks for a voltage advance of that many steps. Because no path can have negative latency, the block delays the current stream by the same count instead.
- **Bit 9 set:** the value, 512 to 575, asks for a voltage delay, given by the low bits. The block delays the voltage stream.

Any other value is refused, and a sticky error flag records the refusal. Each time the skew changes, the output-valid signal drops until the newly selected delay line holds enough fresh samples.

Top module: `phase_skew_cal`

## Requirements
- R1: After reset the calibration value reads back as 0, `out_vld` is 0 and `cal_err` is 0.
- R2: The delay lines and outputs advance only on cycles with `smp_vld` high. On other cycles `cur_out` and `vol_out` hold their values.
- R3: With stored code C in 0..383 (bit 9 = 0), the output produced on a strobe carries the current sample from C strobes earlier and the voltage sample from the same strobe.
- R4: With stored code C in 512..575 (bit 9 = 1), the output produced on a strobe carries the voltage sample from C−512 strobes earlier (bits 5:0) and the current sample from the same strobe.
- R5: A write whose bits 9:0 lie in 384..511 or 576..1023 is refused. The stored code is unchanged and `cal_err` is set in the cycle after the write.
- R6: `cal_err` stays set until a read strobe `reg_rd`, and it is 0 in the cycle after a read that coincides with no refused write.
- R7: After an accepted write of a code with delay D, `out_vld` is 0 from the next cycle. It rises with the output of the (D+1)-th strobe after the write. A refused write leaves `out_vld` unchanged.
- R8: `reg_rdata` is {6'b0, code}. Write bits 15:10 are ignored, so a write of 16'hFC05 stores code 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | One-cycle strobe per sample period |
| cur_in | input | 24 | Signed current sample |
| vol_in | input | 24 | Signed voltage sample |
| reg_wr | input | 1 | Calibration write strobe |
| reg_rd | input | 1 | Calibration read strobe (clears the error flag) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, {6'b0, code} |
| cal_err | output | 1 | Sticky flag for a refused write |
| cur_out | output | 24 | Aligned current sample |
| vol_out | output | 24 | Aligned voltage sample |
| out_vld | output | 1 | Outputs come from a fully refilled delay line |

## Verification
Each aligned sample and its valid flag are registered on the clock edge that takes the strobe, so they are due one cycle after the strobe is driven. The bench drives on falling edges and samples on the next falling edge. The error flag and the drop of `out_vld` after a write are due one cycle after the write and are sampled the same way. Read data is combinational and is sampled while the read strobe is still high. Skew is measured against ramp stimulus: the current input carries the strobe index and the voltage input carries its negation, so every check compares the outputs with the index shifted by the decoded step count.

// File: rtl/phase_skew_cal.sv
`timescale 1ns/1ps
module phase_skew_cal #(
  parameter int DATA_W    = 24,
  parameter int CUR_DEPTH = 384,
  parameter int VOL_DEPTH = 64,
  parameter int CAL_W     = 10,
  parameter int REG_W     = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_vld,
  input  logic signed [DATA_W-1:0] cur_in,
  input  logic signed [DATA_W-1:0] vol_in,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [REG_W-1:0]         reg_wdata,
  output logic [REG_W-1:0]         reg_rdata,
  output logic                     cal_err,
  output logic signed [DATA_W-1:0] cur_out,
  output logic signed [DATA_W-1:0] vol_out,
  output logic                     out_vld
);
  localparam int SEL = CAL_W - 1;
  localparam int CPW = $clog2(CUR_DEPTH);
  localparam int VPW = $clog2(VOL_DEPTH);
  localparam int FW  = $clog2(CUR_DEPTH + 1);
  localparam logic [SEL-1:0] C_LIM  = SEL'(CUR_DEPTH);
  localparam logic [SEL-1:0] V_LIM  = SEL'(VOL_DEPTH);
  localparam logic [CPW-1:0] C_LAST = CPW'(CUR_DEPTH - 1);
  localparam logic [VPW-1:0] V_LAST = VPW'(VOL_DEPTH - 1);
  localparam logic [CPW-1:0] C_SZ   = CPW'(CUR_DEPTH);
  localparam logic [VPW-1:0] V_SZ   = VPW'(VOL_DEPTH);
  localparam logic [FW-1:0]  F_MAX  = FW'(CUR_DEPTH);

  logic [CAL_W-1:0] cal;
  logic [CPW-1:0]   wp_c, ri_c, dly_c;
  logic [VPW-1:0]   wp_v, ri_v, dly_v;
  logic [FW-1:0]    fill, dly_max;
  logic [DATA_W-1:0] cmem [CUR_DEPTH];
  logic [DATA_W-1:0] vmem [VOL_DEPTH];

  wire [CAL_W-1:0] wcode = reg_wdata[CAL_W-1:0];
  wire wr_ok  = wcode[SEL] ? (wcode[SEL-1:0] < V_LIM) : (wcode[SEL-1:0] < C_LIM);
  wire wr_acc = reg_wr && wr_ok;
  wire wr_rej = reg_wr && !wr_ok;

  assign reg_rdata = REG_W'(cal);
  assign dly_c   = cal[SEL] ? '0 : CPW'(cal[SEL-1:0]);
  assign dly_v   = cal[SEL] ? VPW'(cal[SEL-1:0]) : '0;
  assign dly_max = cal[SEL] ? FW'(dly_v) : FW'(dly_c);
  assign ri_c    = (wp_c >= dly_c) ? wp_c - dly_c : wp_c + C_SZ - dly_c;
  assign ri_v    = (wp_v >= dly_v) ? wp_v - dly_v : wp_v + V_SZ - dly_v;

  always_ff @(posedge clk) begin
    if (smp_vld) begin
      cmem[wp_c] <= cur_in;
      vmem[wp_v] <= vol_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cal     <= '0;
      cal_err <= 1'b0;
      wp_c    <= '0;
      wp_v    <= '0;
      fill    <= '0;
      out_vld <= 1'b0;
      cur_out <= '0;
      vol_out <= '0;
    end else begin
      if (wr_rej)      cal_err <= 1'b1;
      else if (reg_rd) cal_err <= 1'b0;
      if (smp_vld) begin
        wp_c    <= (wp_c == C_LAST) ? '0 : wp_c + 1'b1;
        wp_v    <= (wp_v == V_LAST) ? '0 : wp_v + 1'b1;
        cur_out <= (dly_c == '0) ? cur_in : cmem[ri_c];
        vol_out <= (dly_v == '0) ? vol_in : vmem[ri_v];
      end
      if (wr_acc) begin
        cal     <= wcode;
        fill    <= '0;
        out_vld <= 1'b0;
      end else if (smp_vld) begin
        out_vld <= (fill >= dly_max);
        if (fill != F_MAX) fill <= fill + 1'b1;
      end
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(cur_out) && $stable(vol_out));
  p_legal_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cal[SEL] ? (cal[SEL-1:0] < V_LIM) : (cal[SEL-1:0] < C_LIM));
  p_reject_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rej |=> $stable(reg_rdata) && cal_err);
  p_err_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && !wr_rej |=> !cal_err);
  p_vld_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> !out_vld);
  p_vld_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld && !wr_acc |=> $stable(out_vld));
endmodule

// File: tb/phase_skew_cal_tb.sv
`timescale 1ns/1ps
module phase_skew_cal_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, smp_vld = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic signed [23:0] cur_in = '0, vol_in = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic cal_err, out_vld;
  logic signed [23:0] cur_out, vol_out;
  int n_chk = 0, n_fail = 0, k = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  phase_skew_cal dut_i (.clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .cur_in(cur_in),
    .vol_in(vol_in), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cal_err(cal_err), .cur_out(cur_out), .vol_out(vol_out),
    .out_vld(out_vld));

  // {accepted, expected code afterwards, written word}
  localparam logic [26:0] VEC [11] = '{
    {1'b1, 10'd0,   16'd0},    {1'b1, 10'd383, 16'd383},  {1'b1, 10'd512, 16'd512},
    {1'b1, 10'd575, 16'd575},  {1'b0, 10'd575, 16'd384},  {1'b0, 10'd575, 16'd511},
    {1'b0, 10'd575, 16'd576},  {1'b0, 10'd575, 16'd1023}, {1'b1, 10'd5,   16'hFC05},
    {1'b1, 10'd530, 16'd530},  {1'b1, 10'd100, 16'd100}};

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk);
    smp_vld = 1'b1; cur_in = 24'(k); vol_in = -24'(k);
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 100000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(reg_rdata == 16'd0, "R1", "reset code", reg_rdata, 0);
    chk(out_vld == 1'b0, "R1", "reset out_vld", out_vld, 0);
    chk(cal_err == 1'b0, "R1", "reset cal_err", cal_err, 0);

    for (int i = 0; i < 11; i++) begin
      automatic logic [15:0] w = VEC[i][15:0];
      automatic logic [9:0] ec = VEC[i][25:16];
      automatic bit acc = VEC[i][26];
      automatic int dc = ec[9] ? 0 : int'(ec[8:0]);
      automatic int dv = ec[9] ? int'(ec[5:0]) : 0;
      automatic int d = dc + dv;
      @(negedge clk); reg_wr = 1'b1; reg_wdata = w;
      @(negedge clk); reg_wr = 1'b0;
      chk(cal_err == !acc, "R5", "err after write", cal_err, !acc);
      if (acc) chk(out_vld == 1'b0, "R7", "vld drop", out_vld, 0);
      else     chk(out_vld == 1'b1, "R7", "vld kept on refusal", out_vld, 1);
      reg_rd = 1'b1; #1;
      chk(reg_rdata == {6'b0, ec}, "R8", "readback", reg_rdata, ec);
      @(negedge clk); reg_rd = 1'b0;
      chk(cal_err == 1'b0, "R6", "err cleared by read", cal_err, 0);
      for (int j = 1; j <= d + 4; j++) begin
        automatic bit ev = acc ? (j >= d + 1) : 1'b1;
        strobe();
        chk(out_vld == ev, "R7", "out_vld", out_vld, ev);
        if (ev) begin
          chk(cur_out == 24'(k - dc), ec[9] ? "R4" : "R3", "current skew", cur_out, k - dc);
          chk(vol_out == -24'(k - dv), ec[9] ? "R4" : "R3", "voltage skew", vol_out, -(k - dv));
        end
        k++;
      end
    end

    begin : hold_r2
      automatic logic signed [23:0] c0 = cur_out, v0 = vol_out;
      repeat (3) @(negedge clk);
      chk(cur_out == c0, "R2", "current hold", cur_out, c0);
      chk(vol_out == v0, "R2", "voltage hold", vol_out, v0);
    end

    @(negedge clk); reg_wr = 1'b1; reg_wdata = 16'd600;
    @(negedge clk); reg_wr = 1'b0;
    repeat (4) @(negedge clk);
    chk(cal_err == 1'b1, "R6", "err sticky", cal_err, 1);
    chk(reg_rdata == 16'd100, "R5", "code kept", reg_rdata, 100);
    finish_run();
  end
endmodule